// File: doc/BRIEF.md
# Circular Sample Stream Writer

This block carries a stream of 12-bit converter samples into a circular region of memory with no processor involvement per sample. Each conversion-done strobe produces exactly one memory write. The sample word always comes from the same source, and the destination index advances by one element per write. After the last element of the programmed region, the index returns to the region base and acquisition carries on. Capture never stops by itself.

The region is split into a lower half and an upper half so that a consumer can work on one half while the other fills. Two sticky event flags report progress. The half flag rises once the lower half is full, and the complete flag rises once the upper half is full. The consumer returns each half with its own acknowledge pulse. A half that starts to be refilled while it is still unacknowledged is counted in a saturating overrun counter. A remaining-transfer count shows how many writes are left before the next wrap.

The sequencer has two states. `ST_IDLE` ignores strobes and accepts new configuration. `ST_RUN` streams samples. The transition *arm* (ST_IDLE to ST_RUN) fires when enable is high and the length is legal. The transition *halt* (ST_RUN to ST_IDLE) fires when enable drops. On *arm*, the length, base, increment mode and counters are captured, and both halves are marked as free.

Top module: `ring_stream_writer`

## Requirements
- R1: While active, each cycle with `conv_done` high asserts `mem_we` in that same cycle with `mem_wdata` equal to `sample_in`. While idle, `mem_we` stays low whatever `conv_done` does.
- R2: With `cfg_inc` = 1 latched, write number k of a lap (k counted from 0) goes to `mem_addr` = base + k.
- R3: After the write to index length-1, the next write goes back to the base address and streaming continues.
- R4: `ht_flag` reads 1 from the cycle after the write to index length/2-1.
- R5: `tc_flag` reads 1 from the cycle after the write to index length-1.
- R6: Each flag stays set until its clear input is pulsed. When a setting write and the clear fall in the same cycle, the flag stays 1.
- R7: With `cfg_inc` = 0 latched, every write goes to the base address.
- R8: `xfer_left` reads 500 after reset. It reads the latched length after arming, drops by one per write, and reloads to the length on the write that wraps.
- R9: A half is pending from its fill event until its acknowledge (`ack_lo` for the lower half, `ack_hi` for the upper half). The first write into a pending half raises `overrun_cnt` by 1 in the next cycle. An acknowledge that arrives earlier, or in the same cycle as that write, prevents the increment.
- R10: `overrun_cnt` saturates at 65535 and returns to 0 only on reset or an `ovr_clr` pulse.
- R11: Arming is refused (`active` stays 0) if `cfg_len` is odd or below 2. Changes to `cfg_len` while active have no effect.
- R12: Dropping `enable` makes the block idle. Re-arming restarts at the base address with the full count and with both halves free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Start/run control |
| cfg_len | input | 16 | Region length in elements (even, at least 2) |
| cfg_base | input | 16 | Region base address |
| cfg_inc | input | 1 | 1 = destination increments, 0 = fixed destination |
| conv_done | input | 1 | Conversion-done strobe, one write each |
| sample_in | input | 12 | Sample word from the fixed source |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 12 | Memory write data |
| ht_flag | output | 1 | Sticky lower-half-full event |
| ht_clr | input | 1 | Clear pulse for ht_flag |
| tc_flag | output | 1 | Sticky upper-half-full event |
| tc_clr | input | 1 | Clear pulse for tc_flag |
| ack_lo | input | 1 | Consumer finished the lower half |
| ack_hi | input | 1 | Consumer finished the upper half |
| ovr_clr | input | 1 | Clears the overrun counter |
| overrun_cnt | output | 16 | Saturating overrun count |
| xfer_left | output | 16 | Writes remaining before the next wrap |
| active | output | 1 | 1 while in ST_RUN |

## Verification
A stuck or mis-stepped index is visible on `mem_addr` at the very next strobe. It also shows in `xfer_left` one cycle after the write, and it moves the flag events away from lap positions length/2 and length. A pending bit that is set or cleared wrongly stays hidden until the affected half is refilled, which can be up to one full lap later. At that write, `overrun_cnt` either fails to step or steps when it should not. For this reason the checks follow several complete laps with acknowledges given early, in the same cycle as the refill, and not at all.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rsw_state_e;

    localparam int unsigned RSW_DEFAULT_LEN = 500;
    localparam int unsigned RSW_SAMPLE_W    = 12;
    localparam int unsigned RSW_HALVES      = 2;
endpackage

// File: rtl/rsw_seq.sv
module rsw_seq
    import rsw_pkg::*;
#(
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_inc,
    input  logic              conv_done,
    output logic              active,
    output logic              start_pulse,
    output logic              wr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              half_evt,
    output logic              full_evt,
    output logic              lo_refill,
    output logic              hi_refill,
    output logic [LEN_W-1:0]  xfer_left
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    rsw_state_e state_q, state_d;
    logic [LEN_W-1:0]  len_q, idx_q, left_q;
    logic [ADDR_W-1:0] base_q;
    logic              inc_q;
    logic              len_ok;
    logic [LEN_W-1:0]  half_len;

    assign len_ok   = (cfg_len[0] == 1'b0) && (cfg_len >= LEN_W'(2));
    assign half_len = len_q >> 1;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable && len_ok) state_d = ST_RUN;   // arm
            ST_RUN:  if (!enable)          state_d = ST_IDLE;  // halt
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        active      = 1'b0;
        start_pulse = 1'b0;
        wr          = 1'b0;
        unique case (state_q)
            ST_IDLE: start_pulse = (state_d == ST_RUN);
            ST_RUN: begin
                active = 1'b1;
                wr     = conv_done;
            end
            default: ;
        endcase
    end

    assign half_evt  = wr && (idx_q == half_len - ONE);
    assign full_evt  = wr && (idx_q == len_q - ONE);
    assign lo_refill = wr && (idx_q == '0);
    assign hi_refill = wr && (idx_q == half_len);
    assign wr_addr   = base_q + (inc_q ? ADDR_W'(idx_q) : '0);
    assign xfer_left = left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= LEN_W'(RSW_DEFAULT_LEN);
            left_q <= LEN_W'(RSW_DEFAULT_LEN);
            idx_q  <= '0;
            base_q <= '0;
            inc_q  <= 1'b1;
        end else if (start_pulse) begin
            len_q  <= cfg_len;
            left_q <= cfg_len;
            idx_q  <= '0;
            base_q <= cfg_base;
            inc_q  <= cfg_inc;
        end else if (wr) begin
            if (full_evt) begin
                idx_q  <= '0;
                left_q <= len_q;
            end else begin
                idx_q  <= idx_q + ONE;
                left_q <= left_q - ONE;
            end
        end
    end

    a_r2_idx_step: assert property (@(posedge clk) disable iff (rst)
        (wr && !full_evt) |=> (idx_q == $past(idx_q) + ONE));
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (wr && full_evt) |=> (idx_q == '0 && left_q == len_q));
    a_r8_left_range: assert property (@(posedge clk) disable iff (rst)
        active |-> (left_q >= ONE && left_q <= len_q));
    a_r11_len_frozen: assert property (@(posedge clk) disable iff (rst)
        (active && !start_pulse) |=> (!active || $stable(len_q)));
endmodule

// File: rtl/rsw_sticky.sv
module rsw_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/rsw_overrun.sv
module rsw_overrun
    import rsw_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_pulse,
    input  logic [RSW_HALVES-1:0] evt,
    input  logic [RSW_HALVES-1:0] refill,
    input  logic [RSW_HALVES-1:0] ack,
    input  logic             ovr_clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] MAX = '1;

    logic [RSW_HALVES-1:0] pend_q, hit;

    for (genvar g = 0; g < RSW_HALVES; g++) begin : g_half
        assign hit[g] = refill[g] && pend_q[g] && !ack[g];
        always_ff @(posedge clk) begin
            if (rst || start_pulse)      pend_q[g] <= 1'b0;
            else if (evt[g])             pend_q[g] <= 1'b1;
            else if (ack[g] || hit[g])   pend_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ovr_clr)             cnt <= '0;
        else if ((|hit) && cnt != MAX)  cnt <= cnt + CNT_W'(1);
    end

    a_r9_step: assert property (@(posedge clk) disable iff (rst)
        (!ovr_clr && cnt != MAX) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
    a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAX && !ovr_clr) |=> (cnt == MAX));
endmodule

// File: rtl/ring_stream_writer.sv
module ring_stream_writer
    import rsw_pkg::*;
#(
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned SAMPLE_W = RSW_SAMPLE_W,
    parameter int unsigned CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic                cfg_inc,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_wdata,
    output logic                ht_flag,
    input  logic                ht_clr,
    output logic                tc_flag,
    input  logic                tc_clr,
    input  logic                ack_lo,
    input  logic                ack_hi,
    input  logic                ovr_clr,
    output logic [CNT_W-1:0]    overrun_cnt,
    output logic [LEN_W-1:0]    xfer_left,
    output logic                active
);
    logic wr, start_pulse, half_evt, full_evt, lo_refill, hi_refill;
    logic [RSW_HALVES-1:0] evt_v, clr_v, flag_v;

    rsw_seq #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .enable(enable),
        .cfg_len(cfg_len), .cfg_base(cfg_base), .cfg_inc(cfg_inc),
        .conv_done(conv_done), .active(active), .start_pulse(start_pulse),
        .wr(wr), .wr_addr(mem_addr), .half_evt(half_evt), .full_evt(full_evt),
        .lo_refill(lo_refill), .hi_refill(hi_refill), .xfer_left(xfer_left)
    );

    assign evt_v = {full_evt, half_evt};
    assign clr_v = {tc_clr, ht_clr};

    for (genvar g = 0; g < RSW_HALVES; g++) begin : g_flag
        rsw_sticky u_flag (
            .clk(clk), .rst(rst), .set(evt_v[g]), .clr(clr_v[g]), .flag(flag_v[g])
        );
    end

    assign ht_flag = flag_v[0];
    assign tc_flag = flag_v[1];

    rsw_overrun #(.CNT_W(CNT_W)) u_ovr (
        .clk(clk), .rst(rst), .start_pulse(start_pulse),
        .evt(evt_v), .refill({hi_refill, lo_refill}), .ack({ack_hi, ack_lo}),
        .ovr_clr(ovr_clr), .cnt(overrun_cnt)
    );

    assign mem_we    = wr;
    assign mem_wdata = sample_in;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mem_we);
endmodule

// File: tb/tb_ring_stream_writer.sv
module tb_ring_stream_writer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, enable, cfg_inc, conv_done, ht_clr, tc_clr, ack_lo, ack_hi, ovr_clr;
    logic [15:0] cfg_len, cfg_base;
    logic [11:0] sample_in;
    logic        mem_we, ht_flag, tc_flag, active;
    logic [15:0] mem_addr, overrun_cnt, xfer_left;
    logic [11:0] mem_wdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_stream_writer dut (
        .clk(clk), .rst(rst), .enable(enable), .cfg_len(cfg_len), .cfg_base(cfg_base),
        .cfg_inc(cfg_inc), .conv_done(conv_done), .sample_in(sample_in),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ht_flag(ht_flag), .ht_clr(ht_clr), .tc_flag(tc_flag), .tc_clr(tc_clr),
        .ack_lo(ack_lo), .ack_hi(ack_hi), .ovr_clr(ovr_clr),
        .overrun_cnt(overrun_cnt), .xfer_left(xfer_left), .active(active)
    );

    // {sample, expected addr, expected xfer_left after, ht after, tc after}
    localparam logic [45:0] VEC [10] = '{
        {12'hA00, 16'h0100, 16'd7, 1'b0, 1'b0},
        {12'hA01, 16'h0101, 16'd6, 1'b0, 1'b0},
        {12'hA02, 16'h0102, 16'd5, 1'b0, 1'b0},
        {12'hA03, 16'h0103, 16'd4, 1'b1, 1'b0},
        {12'hA04, 16'h0104, 16'd3, 1'b1, 1'b0},
        {12'hA05, 16'h0105, 16'd2, 1'b1, 1'b0},
        {12'hA06, 16'h0106, 16'd1, 1'b1, 1'b0},
        {12'hA07, 16'h0107, 16'd8, 1'b1, 1'b1},
        {12'hA08, 16'h0100, 16'd7, 1'b1, 1'b1},
        {12'hA09, 16'h0101, 16'd6, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one strobe: drive at negedge, check write port, then registered state after edge
    task automatic strobe(input logic [11:0] s, input logic [15:0] exp_addr, input string tag);
        @(negedge clk);
        conv_done = 1'b1;
        sample_in = s;
        #1;
        chk(mem_we === 1'b1, {tag, " we"}, int'(mem_we), 1);
        chk(mem_addr === exp_addr, {tag, " addr"}, int'(mem_addr), int'(exp_addr));
        chk(mem_wdata === s, {tag, " data"}, int'(mem_wdata), int'(s));
        @(posedge clk);
        #1;
        conv_done = 1'b0;
        ht_clr = 1'b0; tc_clr = 1'b0; ack_lo = 1'b0; ack_hi = 1'b0;
    endtask

    task automatic pulse_cycle();
        @(negedge clk);
        @(posedge clk);
        #1;
        ht_clr = 1'b0; tc_clr = 1'b0; ack_lo = 1'b0; ack_hi = 1'b0; ovr_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; enable = 1'b0; cfg_inc = 1'b1; conv_done = 1'b0;
        ht_clr = 1'b0; tc_clr = 1'b0; ack_lo = 1'b0; ack_hi = 1'b0; ovr_clr = 1'b0;
        cfg_len = 16'd8; cfg_base = 16'h0100; sample_in = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state (R8)
        @(negedge clk);
        chk(active === 1'b0, "R12 reset idle", int'(active), 0);
        chk(xfer_left === 16'd500, "R8 reset left", int'(xfer_left), 500);
        chk(ht_flag === 1'b0 && tc_flag === 1'b0, "R4 R5 reset flags", int'({ht_flag, tc_flag}), 0);
        chk(overrun_cnt === 16'd0, "R10 reset count", int'(overrun_cnt), 0);

        // strobe while idle (R1)
        conv_done = 1'b1;
        #1 chk(mem_we === 1'b0, "R1 idle no write", int'(mem_we), 0);
        @(posedge clk); #1 conv_done = 1'b0;

        // illegal lengths refused (R11)
        @(negedge clk); cfg_len = 16'd7; enable = 1'b1;
        @(posedge clk); #1 chk(active === 1'b0, "R11 odd length refused", int'(active), 0);
        @(negedge clk); cfg_len = 16'd0;
        @(posedge clk); #1 chk(active === 1'b0, "R11 zero length refused", int'(active), 0);

        // arm with length 8
        @(negedge clk); cfg_len = 16'd8;
        @(posedge clk); #1;
        chk(active === 1'b1, "R12 armed", int'(active), 1);
        chk(xfer_left === 16'd8, "R8 arm left", int'(xfer_left), 8);
        cfg_len = 16'd4; // no effect while active (R11)

        // table walk: R1 R2 R3 R4 R5 R8 R11
        for (int k = 0; k < 10; k++) begin
            strobe(VEC[k][45:34], VEC[k][33:18], $sformatf("R2 R3 vec%0d", k));
            chk(xfer_left === VEC[k][17:2], $sformatf("R8 vec%0d left", k), int'(xfer_left), int'(VEC[k][17:2]));
            chk(ht_flag === VEC[k][1], $sformatf("R4 vec%0d ht", k), int'(ht_flag), int'(VEC[k][1]));
            chk(tc_flag === VEC[k][0], $sformatf("R5 vec%0d tc", k), int'(tc_flag), int'(VEC[k][0]));
        end
        chk(overrun_cnt === 16'd1, "R9 unacked lower half refilled", int'(overrun_cnt), 1);

        // flag clear and set-wins (R6)
        @(negedge clk); ht_clr = 1'b1; pulse_cycle();
        chk(ht_flag === 1'b0, "R6 ht cleared", int'(ht_flag), 0);
        chk(tc_flag === 1'b1, "R6 tc held", int'(tc_flag), 1);
        strobe(12'h111, 16'h0102, "R2 idx2");
        ht_clr = 1'b1;
        strobe(12'h222, 16'h0103, "R2 idx3");
        chk(ht_flag === 1'b1, "R6 set wins over clear", int'(ht_flag), 1);
        @(negedge clk); tc_clr = 1'b1; pulse_cycle();
        chk(tc_flag === 1'b0, "R6 tc cleared", int'(tc_flag), 0);

        // acknowledge handling (R9)
        @(negedge clk); ack_hi = 1'b1; pulse_cycle();
        strobe(12'h333, 16'h0104, "R9 idx4 after ack");
        chk(overrun_cnt === 16'd1, "R9 early ack prevents overrun", int'(overrun_cnt), 1);
        strobe(12'h005, 16'h0105, "R9 idx5");
        strobe(12'h006, 16'h0106, "R9 idx6");
        strobe(12'h007, 16'h0107, "R9 idx7");
        ack_lo = 1'b1;
        strobe(12'h008, 16'h0100, "R9 idx0 same-cycle ack");
        chk(overrun_cnt === 16'd1, "R9 same-cycle ack prevents overrun", int'(overrun_cnt), 1);
        strobe(12'h009, 16'h0101, "R9 idx1");
        strobe(12'h00A, 16'h0102, "R9 idx2");
        strobe(12'h00B, 16'h0103, "R9 idx3");
        strobe(12'h00C, 16'h0104, "R9 idx4 no ack");
        chk(overrun_cnt === 16'd2, "R9 unacked upper half refilled", int'(overrun_cnt), 2);

        // halt, idle strobe, re-arm fixed-address length 4 (R7 R12)
        @(negedge clk); enable = 1'b0;
        @(posedge clk); #1 chk(active === 1'b0, "R12 halted", int'(active), 0);
        @(negedge clk); conv_done = 1'b1;
        #1 chk(mem_we === 1'b0, "R12 halted no write", int'(mem_we), 0);
        @(posedge clk); #1 conv_done = 1'b0;
        @(negedge clk); cfg_len = 16'd4; cfg_base = 16'h0200; cfg_inc = 1'b0; enable = 1'b1;
        @(posedge clk); #1;
        chk(xfer_left === 16'd4, "R12 rearm full count", int'(xfer_left), 4);
        strobe(12'h0F0, 16'h0200, "R7 fixed w0");
        chk(overrun_cnt === 16'd2, "R12 halves free after rearm", int'(overrun_cnt), 2);
        chk(xfer_left === 16'd3, "R8 left w0", int'(xfer_left), 3);
        strobe(12'h0F1, 16'h0200, "R7 fixed w1");
        strobe(12'h0F2, 16'h0200, "R7 fixed w2");
        strobe(12'h0F3, 16'h0200, "R7 fixed w3");
        chk(xfer_left === 16'd4, "R8 reload at wrap", int'(xfer_left), 4);
        strobe(12'h0F4, 16'h0200, "R7 fixed w4");
        chk(overrun_cnt === 16'd3, "R9 lap two overrun", int'(overrun_cnt), 3);

        // counter clear and saturation (R10)
        @(negedge clk); ovr_clr = 1'b1; pulse_cycle();
        chk(overrun_cnt === 16'd0, "R10 clear", int'(overrun_cnt), 0);
        @(negedge clk); enable = 1'b0;
        @(negedge clk); cfg_len = 16'd2; enable = 1'b1;
        @(negedge clk); conv_done = 1'b1;
        repeat (65600) @(posedge clk);
        #1 conv_done = 1'b0;
        @(negedge clk);
        chk(overrun_cnt === 16'hFFFF, "R10 saturates", int'(overrun_cnt), 65535);
        ovr_clr = 1'b1; pulse_cycle();
        chk(overrun_cnt === 16'd0, "R10 clear after saturation", int'(overrun_cnt), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule